// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block orders the chip's reset. It runs on the half-cycle time unit of the core clock. Five things can start a reset: leaving its own power-on reset, a low level on the external active-low reset pin, a software request, a watchdog overflow, or, as a kind of reset pin low, a low supply flag. Each of these starts one fixed 1024-cycle internal sequence. If the external pin is still low when that sequence would finish, the reset is stretched until the pin rises. A short delay follows, and then the block captures the port configuration word and starts instruction fetch at address zero.

A reset from the pin, or from power-on, captures every bit of the 16-bit port. A reset from software or from the watchdog refreshes only a middle field of the port and zeroes a lower field. The other bits keep their old values. The block can also pull the bidirectional reset pin low during a reset it started itself, if software armed that beforehand. While the supply flag shows a low level with the pin asserted, the block takes the asynchronous path and releases that pull.

Top module: `reset_sequencer`

## Requirements
- R1: While `rst_n` is low, `irst` and `rst_out` are 1 and `cfg_word`, `rst_cause`, `pin_pull`, `cfg_strobe` and `fetch_start` are 0. After `rst_n` rises, `cfg_strobe` pulses 1024+L cycles later with a full port capture and `rst_cause` = 0 (power-on).
- R2: `rstin_n` passes through a two-flop synchroniser. A low level that is present at three consecutive rising edges has `irst` high after the third edge, and `irst` is still low after the second.
- R3: A pin pulse that ends before the sequence finishes gives a short reset. `cfg_strobe` comes 1027+L cycles after the falling edge and `rst_cause` = 1.
- R4: If the synchronised pin is still low at the end of the 1024-cycle sequence, `irst` stays high and no strobe occurs until the pin rises. The strobe then comes L+3 cycles after the rising edge, with `rst_cause` = 2.
- R5: The latch delay L is 8 cycles, or 6 cycles when `pll_bypass` = 1.
- R6: A reset from power-on or from the pin loads all 16 bits of `port_in` into `cfg_word`.
- R7: A software request (`sw_rst_req` high at an edge while idle) gives `rst_cause` = 4 and a strobe 1025+L cycles later. At the strobe, `cfg_word` bits 12..6 take `port_in`, bits 5..2 become 0, and bits 15..13 and 1..0 keep their old values.
- R8: A watchdog overflow behaves as in R7 with `rst_cause` = 5. When requests coincide, the pin wins over the watchdog, and the watchdog wins over software.
- R9: A request that arrives while a sequence is running has no effect: only one strobe occurs, the cause is unchanged, and no new reset follows.
- R10: `bidir_arm` sets an enable while idle. During the 1024-cycle part of a software or watchdog reset, `pin_pull` is then 1. The enable is cleared at the end of every sequence, and `pin_pull` is never high outside reset.
- R11: If `vpd_low` = 1 while the synchronised pin is low during reset, `rst_cause` becomes 3 and `pin_pull` falls to 0 for the rest of that sequence.
- R12: In the strobe cycle `irst` is 0 and `rst_out` is still 1. In the next cycle `fetch_start` is high for one cycle with `fetch_addr` = 0, and `rst_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle time-unit clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rstin_n | input | 1 | External reset pin level, active low |
| sw_rst_req | input | 1 | Software reset request |
| wdt_ovf | input | 1 | Watchdog overflow request |
| pll_bypass | input | 1 | Strap: PLL bypassed, shorter latch delay |
| vpd_low | input | 1 | Power-down supply flag below threshold |
| bidir_arm | input | 1 | Arms the pull on the reset pin for the next internal reset |
| port_in | input | 16 | Configuration port levels |
| irst | output | 1 | Internal reset |
| rst_out | output | 1 | Reset-out; releases when fetch starts |
| pin_pull | output | 1 | Open-drain pull-down enable for the reset pin |
| cfg_strobe | output | 1 | One-cycle configuration latch strobe |
| cfg_word | output | 16 | Captured configuration word |
| fetch_start | output | 1 | One-cycle start-of-fetch pulse |
| fetch_addr | output | 24 | Fetch vector address |
| rst_cause | output | 3 | Cause code of the last reset |

## Verification
The assertions take `rstin_n` to be a clean level that stays put between edges, and `pll_bypass` to be a strap that does not change while the latch delay counts. They also take the supply flag to rise only while the pin is asserted. The stimulus drives every input at falling edges only and changes the strap only while the block is idle. It raises `vpd_low` only together with a low pin and drops both at once, and it holds the port steady across each latch point.

// File: rtl/rstseq_pkg.sv
// Shared types of the reset sequencer: controller states and the cause code.
package rstseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEQ   = 2'd1,
        ST_EXT   = 2'd2,
        ST_LATCH = 2'd3
    } seq_state_t;

    typedef enum logic [2:0] {
        CAUSE_POWER = 3'd0,
        CAUSE_SHORT = 3'd1,
        CAUSE_LONG  = 3'd2,
        CAUSE_ASYNC = 3'd3,
        CAUSE_SOFT  = 3'd4,
        CAUSE_WDOG  = 3'd5
    } rst_cause_t;

endpackage

// File: rtl/rstseq_sync.sv
// Synchroniser for the external reset pin.
// Assumes STAGES >= 2. It resets to the inactive (high) level, so that
// power-on does not look like a pin reset.
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_sync_n
);

    logic [STAGES-1:0] chain;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], pin_n};
    end

    assign pin_sync_n = chain[STAGES-1];

endmodule

// File: rtl/rstseq_ctrl.sv
// Reset sequence controller.
// It starts the fixed-length sequence, stretches it while the synchronised
// pin is low, waits the latch delay and records the cause. It also owns the
// bidirectional-pull enable. Assumes pll_bypass is a static strap and that
// LAT_PLL and LAT_BYP are no larger than SEQ_LEN.
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int SEQ_LEN = 1024,
    parameter int LAT_PLL = 8,
    parameter int LAT_BYP = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s_n,
    input  logic       sw_req,
    input  logic       wdt_req,
    input  logic       pll_bypass,
    input  logic       vpd_low,
    input  logic       bidir_arm,
    output logic       in_reset,
    output logic       latch_en,
    output logic       latch_partial,
    output logic       strobe,
    output logic       fetch,
    output logic       pull_en,
    output logic [2:0] cause_o
);

    localparam int CNT_W = $clog2(SEQ_LEN);
    localparam logic [CNT_W-1:0] SEQ_LAST = CNT_W'(SEQ_LEN - 1);
    localparam logic [CNT_W-1:0] PLL_LAST = CNT_W'(LAT_PLL - 1);
    localparam logic [CNT_W-1:0] BYP_LAST = CNT_W'(LAT_BYP - 1);

    seq_state_t       state;
    rst_cause_t       cause;
    logic [CNT_W-1:0] cnt;
    logic             internal;
    logic             async_seen;
    logic             bidir_en;
    logic             seq_last;
    logic [CNT_W-1:0] lat_last;

    // Decode the end of the sequence and the latch delay selected by the strap.
    always_comb begin
        seq_last = (cnt == SEQ_LAST);
        lat_last = pll_bypass ? BYP_LAST : PLL_LAST;
        latch_en = (state == ST_LATCH) && pin_s_n && (cnt == lat_last);
    end

    // Main sequencing state machine with its shared counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_SEQ;
            cnt        <= '0;
            cause      <= CAUSE_POWER;
            internal   <= 1'b0;
            async_seen <= 1'b0;
            bidir_en   <= 1'b0;
            strobe     <= 1'b0;
            fetch      <= 1'b0;
        end else begin
            strobe <= 1'b0;
            fetch  <= strobe;
            case (state)
                ST_IDLE: begin
                    async_seen <= 1'b0;
                    if (bidir_arm) bidir_en <= 1'b1;
                    if (!pin_s_n) begin
                        state      <= ST_SEQ;
                        cnt        <= '0;
                        internal   <= 1'b0;
                        async_seen <= vpd_low;
                        cause      <= vpd_low ? CAUSE_ASYNC : CAUSE_SHORT;
                    end else if (wdt_req) begin
                        state    <= ST_SEQ;
                        cnt      <= '0;
                        internal <= 1'b1;
                        cause    <= CAUSE_WDOG;
                    end else if (sw_req) begin
                        state    <= ST_SEQ;
                        cnt      <= '0;
                        internal <= 1'b1;
                        cause    <= CAUSE_SOFT;
                    end
                end
                ST_SEQ: begin
                    cnt <= cnt + 1'b1;
                    if (seq_last) begin
                        cnt <= '0;
                        if (!pin_s_n) begin
                            state <= ST_EXT;
                            if (!async_seen) cause <= CAUSE_LONG;
                        end else begin
                            state <= ST_LATCH;
                        end
                    end
                end
                ST_EXT: begin
                    if (pin_s_n) begin
                        state <= ST_LATCH;
                        cnt   <= '0;
                    end
                end
                default: begin
                    if (!pin_s_n) begin
                        state <= ST_EXT;
                        if (!async_seen) cause <= CAUSE_LONG;
                    end else if (latch_en) begin
                        state    <= ST_IDLE;
                        strobe   <= 1'b1;
                        bidir_en <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
            if (state != ST_IDLE && vpd_low && !pin_s_n) begin
                async_seen <= 1'b1;
                cause      <= CAUSE_ASYNC;
            end
        end
    end

    // Drive the outputs that are decoded from the registered state.
    always_comb begin
        in_reset      = (state != ST_IDLE);
        latch_partial = internal;
        pull_en       = (state == ST_SEQ) && internal && bidir_en && !async_seen;
        cause_o       = cause;
    end

endmodule

// File: rtl/rstseq_cfg.sv
// Configuration word capture.
// On latch_en a full capture loads every port bit. A partial capture
// (software or watchdog reset) loads the KEEP field, clears the CLR field
// and holds the others. Assumes the two fields do not overlap.
module rstseq_cfg #(
    parameter int PORT_W  = 16,
    parameter int KEEP_HI = 12,
    parameter int KEEP_LO = 6,
    parameter int CLR_HI  = 5,
    parameter int CLR_LO  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic              partial,
    input  logic [PORT_W-1:0] port_in,
    output logic [PORT_W-1:0] word
);

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        logic q;
        if (b >= KEEP_LO && b <= KEEP_HI) begin : g_relatch
            // Field refreshed by every kind of capture.
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= 1'b0;
                else if (latch_en) q <= port_in[b];
            end
        end else if (b >= CLR_LO && b <= CLR_HI) begin : g_clear
            // Field zeroed by a partial capture.
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= 1'b0;
                else if (latch_en) q <= partial ? 1'b0 : port_in[b];
            end
        end else begin : g_hold
            // Field loaded only by a full capture.
            always_ff @(posedge clk) begin
                if (!rst_n)                    q <= 1'b0;
                else if (latch_en && !partial) q <= port_in[b];
            end
        end
        assign word[b] = q;
    end

endmodule

// File: rtl/reset_sequencer.sv
// Top of the reset sequencer: pin synchroniser, controller, configuration
// capture and the reset-out flop. Assumes clk is the half-cycle time unit and
// that the pin and strap inputs come straight from pads.
module reset_sequencer #(
    parameter int PORT_W  = 16,
    parameter int ADDR_W  = 24,
    parameter int SYNC_N  = 2,
    parameter int SEQ_LEN = 1024,
    parameter int LAT_PLL = 8,
    parameter int LAT_BYP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rstin_n,
    input  logic              sw_rst_req,
    input  logic              wdt_ovf,
    input  logic              pll_bypass,
    input  logic              vpd_low,
    input  logic              bidir_arm,
    input  logic [PORT_W-1:0] port_in,
    output logic              irst,
    output logic              rst_out,
    output logic              pin_pull,
    output logic              cfg_strobe,
    output logic [PORT_W-1:0] cfg_word,
    output logic              fetch_start,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [2:0]        rst_cause
);

    logic pin_s_n;
    logic latch_en;
    logic latch_partial;

    rstseq_sync #(.STAGES(SYNC_N)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (rstin_n),
        .pin_sync_n (pin_s_n)
    );

    rstseq_ctrl #(
        .SEQ_LEN (SEQ_LEN),
        .LAT_PLL (LAT_PLL),
        .LAT_BYP (LAT_BYP)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_s_n       (pin_s_n),
        .sw_req        (sw_rst_req),
        .wdt_req       (wdt_ovf),
        .pll_bypass    (pll_bypass),
        .vpd_low       (vpd_low),
        .bidir_arm     (bidir_arm),
        .in_reset      (irst),
        .latch_en      (latch_en),
        .latch_partial (latch_partial),
        .strobe        (cfg_strobe),
        .fetch         (fetch_start),
        .pull_en       (pin_pull),
        .cause_o       (rst_cause)
    );

    rstseq_cfg #(.PORT_W(PORT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .partial  (latch_partial),
        .port_in  (port_in),
        .word     (cfg_word)
    );

    // Reset-out follows the internal reset one cycle late, so it releases with fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_out <= 1'b1;
        else        rst_out <= irst;
    end

    assign fetch_addr = '0;

endmodule

// File: rtl/rstseq_chk.sv
// Checker for the reset sequencer, bound to every instance of the top.
module rstseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rstin_n,
    input logic        irst,
    input logic        pin_pull,
    input logic        cfg_strobe,
    input logic        fetch_start,
    input logic [2:0]  rst_cause,
    input logic [15:0] cfg_word
);

    // R2
    pin_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && !$past(rstin_n, 3)) |-> irst);

    // R7
    partial_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_strobe && (rst_cause == 3'd4 || rst_cause == 3'd5)) |-> (cfg_word[5:2] == 4'd0));

    // R9
    strobe_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe |-> $past(irst));

    // R10
    pull_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pull |-> irst);

    // R11
    async_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irst && rst_cause == 3'd3) |-> !pin_pull);

    // R12
    fetch_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe |=> fetch_start);

    // R12
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |=> !fetch_start);

    // R12
    release_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irst) |-> cfg_strobe);

endmodule

bind reset_sequencer rstseq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rstin_n     (rstin_n),
    .irst        (irst),
    .pin_pull    (pin_pull),
    .cfg_strobe  (cfg_strobe),
    .fetch_start (fetch_start),
    .rst_cause   (rst_cause),
    .cfg_word    (cfg_word)
);

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;

    localparam int SEQ = 1024;

    logic        clk = 1'b0;
    logic        rst_n, rstin_n, sw_rst_req, wdt_ovf, pll_bypass, vpd_low, bidir_arm;
    logic [15:0] port_in;
    logic        irst, rst_out, pin_pull, cfg_strobe, fetch_start;
    logic [15:0] cfg_word;
    logic [23:0] fetch_addr;
    logic [2:0]  rst_cause;

    always #2.5 clk = ~clk;

    reset_sequencer i_reset_sequencer (
        .clk(clk), .rst_n(rst_n), .rstin_n(rstin_n), .sw_rst_req(sw_rst_req),
        .wdt_ovf(wdt_ovf), .pll_bypass(pll_bypass), .vpd_low(vpd_low),
        .bidir_arm(bidir_arm), .port_in(port_in), .irst(irst), .rst_out(rst_out),
        .pin_pull(pin_pull), .cfg_strobe(cfg_strobe), .cfg_word(cfg_word),
        .fetch_start(fetch_start), .fetch_addr(fetch_addr), .rst_cause(rst_cause)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] model_cfg = 16'h0;

    typedef struct {
        int          cause;
        logic [15:0] cfg;
        int          start;
        int          edges;
        string       req;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    bit   pend_fetch = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int lat();
        return pll_bypass ? 6 : 8;
    endfunction

    function automatic logic [15:0] part_cfg(input logic [15:0] prev, input logic [15:0] port);
        return (prev & ~16'h1FFC) | (port & 16'h1FC0);
    endfunction

    task automatic push(input int cause, input logic [15:0] cfg, input int start,
                        input int edges, input string req);
        exp_t e;
        e.cause = cause; e.cfg = cfg; e.start = start; e.edges = edges; e.req = req;
        sb.push_back(e);
        model_cfg = cfg;
    endtask

    task automatic wait_done();
        wait (sb.size() == 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic soft_req(input bit wdog, input bit both, input string req);
        sw_rst_req = !wdog || both;
        wdt_ovf    = wdog;
        push(wdog ? 5 : 4, part_cfg(model_cfg, port_in), cyc, SEQ + 1 + lat(), req);
        @(negedge clk);
        sw_rst_req = 1'b0;
        wdt_ovf    = 1'b0;
    endtask

    // Monitor: pops one expected item for every latch strobe.
    always @(negedge clk) begin
        if (pend_fetch) begin
            check(fetch_start === 1'b1 && fetch_addr == 24'h0, "R12", "fetch pulse",
                  fetch_start, 1);
            check(rst_out === 1'b0, "R12", "rst_out after fetch", rst_out, 0);
            pend_fetch = 1'b0;
        end
        if (cfg_strobe === 1'b1) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected strobe", 1, 0);
            end else begin
                cur = sb.pop_front();
                check(rst_cause == cur.cause[2:0], cur.req, "cause", rst_cause, cur.cause);
                check(cfg_word == cur.cfg, cur.req, "cfg_word", cfg_word, cur.cfg);
                check(cyc - cur.start == cur.edges, cur.req, "latency",
                      cyc - cur.start, cur.edges);
                check(irst === 1'b0 && rst_out === 1'b1, "R12", "release at strobe",
                      {irst, rst_out}, 1);
            end
            pend_fetch = 1'b1;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rstin_n = 1'b1; sw_rst_req = 1'b0; wdt_ovf = 1'b0;
        pll_bypass = 1'b0; vpd_low = 1'b0; bidir_arm = 1'b0; port_in = 16'hA5C3;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(irst === 1'b1 && rst_out === 1'b1, "R1", "reset irst/rst_out", {irst, rst_out}, 3);
        check(cfg_word === 16'h0 && rst_cause === 3'd0, "R1", "reset word/cause", cfg_word, 0);
        check(pin_pull === 1'b0 && cfg_strobe === 1'b0 && fetch_start === 1'b0, "R1",
              "reset pulses", {pin_pull, cfg_strobe, fetch_start}, 0);
        rst_n = 1'b1;
        push(0, 16'hA5C3, cyc, SEQ + lat(), "R1");
        wait_done();

        // R3/R6 short pin reset, R2 synchroniser depth, R9 ignored request
        port_in = 16'h3C5A;
        rstin_n = 1'b0;
        push(1, 16'h3C5A, cyc, SEQ + 3 + lat(), "R3");
        repeat (2) @(negedge clk);
        check(irst === 1'b0, "R2", "irst after two edges", irst, 0);
        @(negedge clk);
        check(irst === 1'b1, "R2", "irst after three edges", irst, 1);
        repeat (17) @(negedge clk);
        rstin_n = 1'b1;
        repeat (200) @(negedge clk);
        sw_rst_req = 1'b1;
        @(negedge clk);
        sw_rst_req = 1'b0;
        wait_done();
        repeat (50) @(negedge clk);
        check(irst === 1'b0 && rst_cause === 3'd1, "R9", "no reset after ignored request",
              {irst, rst_cause}, 1);

        // R5 bypassed PLL shortens latch delay
        pll_bypass = 1'b1;
        port_in = 16'hFFFF;
        rstin_n = 1'b0;
        push(1, 16'hFFFF, cyc, SEQ + 3 + lat(), "R5");
        repeat (10) @(negedge clk);
        rstin_n = 1'b1;
        wait_done();
        pll_bypass = 1'b0;

        // R4 long reset
        port_in = 16'h0F0F;
        rstin_n = 1'b0;
        repeat (1300) @(negedge clk);
        check(irst === 1'b1, "R4", "extended reset", irst, 1);
        repeat (200) @(negedge clk);
        rstin_n = 1'b1;
        push(2, 16'h0F0F, cyc, lat() + 3, "R4");
        wait_done();

        // R7 software reset with partial capture
        port_in = 16'hFFFF;
        soft_req(1'b0, 1'b0, "R7");
        wait_done();

        // R8 watchdog wins over a simultaneous software request
        port_in = 16'h1234;
        soft_req(1'b1, 1'b1, "R8");
        wait_done();

        // R10 armed pull during an internal reset, then cleared
        bidir_arm = 1'b1;
        @(negedge clk);
        bidir_arm = 1'b0;
        port_in = 16'h5555;
        soft_req(1'b0, 1'b0, "R7");
        repeat (100) @(negedge clk);
        check(pin_pull === 1'b1, "R10", "pull while armed", pin_pull, 1);
        wait_done();
        check(pin_pull === 1'b0, "R10", "pull after reset", pin_pull, 0);
        soft_req(1'b0, 1'b0, "R7");
        repeat (100) @(negedge clk);
        check(pin_pull === 1'b0, "R10", "enable cleared", pin_pull, 0);
        wait_done();

        // R11 supply flag low during an internal reset drops the pull
        bidir_arm = 1'b1;
        @(negedge clk);
        bidir_arm = 1'b0;
        port_in = 16'hAAAA;
        sw_rst_req = 1'b1;
        push(3, part_cfg(model_cfg, port_in), cyc, SEQ + 1 + lat(), "R11");
        @(negedge clk);
        sw_rst_req = 1'b0;
        repeat (100) @(negedge clk);
        check(pin_pull === 1'b1, "R10", "pull before supply drop", pin_pull, 1);
        vpd_low = 1'b1;
        rstin_n = 1'b0;
        repeat (5) @(negedge clk);
        check(pin_pull === 1'b0, "R11", "pull released", pin_pull, 0);
        vpd_low = 1'b0;
        rstin_n = 1'b1;
        wait_done();

        // R11 external asynchronous reset, full capture
        port_in = 16'h8001;
        vpd_low = 1'b1;
        rstin_n = 1'b0;
        push(3, 16'h8001, cyc, SEQ + 3 + lat(), "R11");
        repeat (10) @(negedge clk);
        vpd_low = 1'b0;
        rstin_n = 1'b1;
        wait_done();

        // R8 pin wins over a watchdog request in the same cycle
        port_in = 16'h6E6E;
        rstin_n = 1'b0;
        push(1, 16'h6E6E, cyc, SEQ + 3 + lat(), "R8");
        repeat (2) @(negedge clk);
        wdt_ovf = 1'b1;
        @(negedge clk);
        wdt_ovf = 1'b0;
        repeat (10) @(negedge clk);
        rstin_n = 1'b1;
        wait_done();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule